// File: doc/BRIEF.md
# PLL Configuration Write Sequencer

This block programs a PHY's PLL through its 8-bit register port, where each write carries a code byte and a data byte. A host gives the block the PLL settings it has chosen and pulses `start`. These settings are:

- the input divider N and the feedback multiplier M,
- the VCO range and VCO capacitance codes,
- the charge-pump current,
- the loop-filter control and two default-bypass flags.

The block copies the settings into registers when it accepts `start`. It then issues seven writes in a fixed order. Each write packs its data byte with the bypass bits and the minus-one encodings set correctly. The 9-bit multiplier value goes out as two writes to the same code, and a selector bit tells the two halves apart.

Each write is a request/acknowledge transfer. `busy` covers the whole run, and `done` pulses once when the run completes. `err` reports two faults: an illegal capacitance code seen at start, and an acknowledge that does not arrive within a programmable number of cycles.

Top module: `pllcfg_seq`

## Requirements
- R1: An accepted start produces exactly seven writes with codes 0x10, 0x11, 0x12, 0x19, 0x17, 0x18, 0x18, in that order.
- R2: The data byte for code 0x10 is {1, 0, vco_rng[2:0], vco_cap[1:0], 0}. Bit 7 is the range-override bit.
- R3: A start that arrives while idle with vco_cap = 2'b11 issues no write and leaves busy low. It sets err on the next cycle.
- R4: The data byte for code 0x11 is {4'b0, cp_cur}. The data byte for code 0x12 is {cp_byp, lf_byp, lf_ctl[5:0]}.
- R5: The data byte for code 0x19 is 0x30. Bit 5 (loop divider override) and bit 4 (input divider override) are set, and all other bits are clear.
- R6: The data byte for code 0x17 is (n_div − 1) in 8 bits.
- R7: Let m = m_mul − 1 in 9 bits. The first 0x18 write carries {3'b000, m[4:0]} and the second carries {1, 3'b000, m[8:5]}.
- R8: While wr_req is high and wr_ack is low, wr_req, wr_code and wr_data hold their values into the next cycle. In the cycle after an acknowledge, wr_req is low.
- R9: busy rises the cycle after an accepted start and stays high until the last acknowledge. In the next cycle busy is low and done is high for exactly one cycle. A start seen while busy has no effect.
- R10: If a write has been requested for max(tmo_lim,1) cycles with no acknowledge, the block drops the request, returns to idle and sets err. An acknowledge in the last allowed cycle is accepted.
- R11: After reset, wr_req, busy, done and err are low. A start accepted with a legal capacitance code clears err on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, sampled while idle |
| n_div | input | N_W | Input divider N (1 or more) |
| m_mul | input | M_W | Feedback multiplier M (1 to 512) |
| vco_rng | input | 3 | VCO range code |
| vco_cap | input | 2 | VCO capacitance code; 2'b11 is illegal |
| cp_cur | input | 4 | Charge-pump current code |
| lf_ctl | input | 6 | Loop-filter control code |
| cp_byp | input | 1 | Charge-pump default bypass flag |
| lf_byp | input | 1 | Loop-filter default bypass flag |
| tmo_lim | input | TMO_W | Maximum number of request cycles per write |
| wr_req | output | 1 | Write request |
| wr_code | output | 8 | Register code of the current write |
| wr_data | output | 8 | Data byte of the current write |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when the sequence completes |
| err | output | 1 | Capacitance or timeout fault, held until the next accepted start |

## Verification
The assertions check several properties on every cycle:

- the request stays stable until an acknowledge or an abort (R8),
- the request drops for one cycle after each acknowledge (R8),
- done is a single-cycle pulse that follows the final high-half 0x18 acknowledge (R9),
- no request stays high for longer than the limit (R10),
- an illegal capacitance code at start is refused (R3),
- the fixed bits of the 0x10 byte are correct (R2).

Only the bench scenarios can show the rest:

- the full seven-write order (R1),
- each data byte compared against values the bench computes from random settings (R4 to R7),
- the M and N edge values (M = 1, M = 512, N = 1),
- an acknowledge in the exact last allowed cycle (R10),
- the clearing of err by a later legal start (R11).

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

   localparam int unsigned NUM_WR = 7;
   localparam int unsigned IDX_W  = $clog2(NUM_WR);
   localparam int unsigned SLOTS  = 1 << IDX_W;

   typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_GAP} seq_st_e;

   typedef struct packed {
      logic [2:0] rng;
      logic [1:0] cap;
      logic [3:0] icp;
      logic [5:0] lpf;
      logic       cp_byp;
      logic       lf_byp;
      logic [7:0] nm1;
      logic [8:0] mm1;
   } pll_cfg_t;

   // Code sent in write slot s; the order is the required programming order.
   function automatic logic [7:0] slot_code(int unsigned s);
      case (s)
         0:       return 8'h10;
         1:       return 8'h11;
         2:       return 8'h12;
         3:       return 8'h19;
         4:       return 8'h17;
         5, 6:    return 8'h18;
         default: return 8'h00;
      endcase
   endfunction

   // Data byte for write slot s, with every reserved bit cleared.
   function automatic logic [7:0] slot_data(int unsigned s, pll_cfg_t c);
      case (s)
         0:       return {1'b1, 1'b0, c.rng, c.cap, 1'b0};
         1:       return {4'b0000, c.icp};
         2:       return {c.cp_byp, c.lf_byp, c.lpf};
         3:       return 8'b0011_0000;
         4:       return c.nm1;
         5:       return {3'b000, c.mm1[4:0]};
         6:       return {1'b1, 3'b000, c.mm1[8:5]};
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/pllcfg_pack.sv
module pllcfg_pack
   import pllcfg_pkg::*;
(
   input  pll_cfg_t         cfg,
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       code,
   output logic [7:0]       data
);

   logic [7:0] code_tab [SLOTS];
   logic [7:0] data_tab [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign code_tab[g] = slot_code(g);
      assign data_tab[g] = slot_data(g, cfg);
   end

   assign code = code_tab[idx];
   assign data = data_tab[idx];

endmodule

// File: rtl/pllcfg_tmo.sv
module pllcfg_tmo #(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [TMO_W-1:0] lim,
   output logic             expire
);

   logic [TMO_W-1:0] cnt;

   // The current cycle is the last allowed one once cnt+1 reaches the limit.
   assign expire = run && (({1'b0, cnt} + (TMO_W+1)'(1)) >= {1'b0, lim});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (!run || expire)  cnt <= '0;
      else                      cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/pllcfg_seq.sv
module pllcfg_seq
   import pllcfg_pkg::*;
#(
   parameter int unsigned N_W   = 8,
   parameter int unsigned M_W   = 10,
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [N_W-1:0]   n_div,
   input  logic [M_W-1:0]   m_mul,
   input  logic [2:0]       vco_rng,
   input  logic [1:0]       vco_cap,
   input  logic [3:0]       cp_cur,
   input  logic [5:0]       lf_ctl,
   input  logic             cp_byp,
   input  logic             lf_byp,
   input  logic [TMO_W-1:0] tmo_lim,
   output logic             wr_req,
   output logic [7:0]       wr_code,
   output logic [7:0]       wr_data,
   input  logic             wr_ack,
   output logic             busy,
   output logic             done,
   output logic             err
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WR - 1);

   initial begin
      assert (N_W >= 1 && N_W <= 8)  else $error("pllcfg_seq: N_W must be 1..8");
      assert (M_W >= 9 && M_W <= 10) else $error("pllcfg_seq: M_W must be 9..10");
      assert (TMO_W >= 2)            else $error("pllcfg_seq: TMO_W must be >= 2");
   end

   seq_st_e          st;
   logic [IDX_W-1:0] idx;
   pll_cfg_t         cfg_q;
   pll_cfg_t         cfg_in;
   logic             expire;
   logic             cap_bad;

   assign cap_bad = (vco_cap == 2'b11);

   always_comb begin
      cfg_in        = '0;
      cfg_in.rng    = vco_rng;
      cfg_in.cap    = vco_cap;
      cfg_in.icp    = cp_cur;
      cfg_in.lpf    = lf_ctl;
      cfg_in.cp_byp = cp_byp;
      cfg_in.lf_byp = lf_byp;
      cfg_in.nm1    = 8'(n_div - N_W'(1));
      cfg_in.mm1    = 9'(m_mul - M_W'(1));
   end

   pllcfg_pack u_pack (
      .cfg  (cfg_q),
      .idx  (idx),
      .code (wr_code),
      .data (wr_data)
   );

   pllcfg_tmo #(.TMO_W(TMO_W)) u_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (wr_req),
      .lim    (tmo_lim),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         idx   <= '0;
         cfg_q <= '0;
         done  <= 1'b0;
         err   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  if (cap_bad) begin
                     err <= 1'b1;
                  end else begin
                     err   <= 1'b0;
                     cfg_q <= cfg_in;
                     idx   <= '0;
                     st    <= ST_REQ;
                  end
               end
            end
            ST_REQ: begin
               if (wr_ack) begin
                  if (idx == LAST_IDX) begin
                     st   <= ST_IDLE;
                     done <= 1'b1;
                  end else begin
                     idx <= idx + 1'b1;
                     st  <= ST_GAP;
                  end
               end else if (expire) begin
                  st  <= ST_IDLE;
                  err <= 1'b1;
               end
            end
            ST_GAP:  st <= ST_REQ;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign wr_req = (st == ST_REQ);
   assign busy   = (st != ST_IDLE);

endmodule

// File: rtl/pllcfg_chk.sv
module pllcfg_chk #(
   parameter int unsigned TMO_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [1:0]       vco_cap,
   input logic [TMO_W-1:0] tmo_lim,
   input logic             wr_req,
   input logic             wr_ack,
   input logic [7:0]       wr_code,
   input logic [7:0]       wr_data,
   input logic             busy,
   input logic             done,
   input logic             err
);

   logic [TMO_W:0] wait_cnt;
   logic [TMO_W:0] lim_eff;

   assign lim_eff = (tmo_lim == '0) ? (TMO_W+1)'(1) : {1'b0, tmo_lim};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wait_cnt <= '0;
      else if (wr_req && !wr_ack) wait_cnt <= wait_cnt + 1'b1;
      else                       wait_cnt <= '0;
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ack) |=> ((wr_req && $stable(wr_code) && $stable(wr_data)) || (err && !busy))); // R8
   AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_ack) |=> !wr_req); // R8
   AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> busy); // R9
   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(wr_req && wr_ack && wr_code == 8'h18 && wr_data[7]))); // R9
   AST_CAP_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && vco_cap == 2'b11) |=> (err && !busy && !wr_req)); // R3
   AST_VCO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_code == 8'h10) |-> (wr_data[7] && !wr_data[6] && !wr_data[0] && wr_data[2:1] != 2'b11)); // R2
   AST_WAIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> (wait_cnt < lim_eff)); // R10

endmodule

bind pllcfg_seq pllcfg_chk #(.TMO_W(TMO_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .vco_cap (vco_cap),
   .tmo_lim (tmo_lim),
   .wr_req  (wr_req),
   .wr_ack  (wr_ack),
   .wr_code (wr_code),
   .wr_data (wr_data),
   .busy    (busy),
   .done    (done),
   .err     (err)
);

// File: tb/sim_pllcfg_seq.sv
`timescale 1ns/1ps
module sim_pllcfg_seq;

   localparam int N_W = 8, M_W = 10, TMO_W = 16;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr_ack = 1'b0;
   logic [N_W-1:0]   n_div = 8'd1;
   logic [M_W-1:0]   m_mul = 10'd1;
   logic [2:0]       vco_rng = '0;
   logic [1:0]       vco_cap = '0;
   logic [3:0]       cp_cur = '0;
   logic [5:0]       lf_ctl = '0;
   logic             cp_byp = 1'b0, lf_byp = 1'b0;
   logic [TMO_W-1:0] tmo_lim = 16'd1000;
   logic             wr_req, busy, done, err;
   logic [7:0]       wr_code, wr_data;

   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   pllcfg_seq #(.N_W(N_W), .M_W(M_W), .TMO_W(TMO_W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .n_div(n_div), .m_mul(m_mul),
      .vco_rng(vco_rng), .vco_cap(vco_cap), .cp_cur(cp_cur), .lf_ctl(lf_ctl),
      .cp_byp(cp_byp), .lf_byp(lf_byp), .tmo_lim(tmo_lim),
      .wr_req(wr_req), .wr_code(wr_code), .wr_data(wr_data), .wr_ack(wr_ack),
      .busy(busy), .done(done), .err(err));

   task automatic chk(input bit ok, input string tag, input int got, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
      end
   endtask

   function automatic logic [7:0] exp_code(int i);
      logic [7:0] codes [7] = '{8'h10, 8'h11, 8'h12, 8'h19, 8'h17, 8'h18, 8'h18};
      return codes[i];
   endfunction

   function automatic logic [7:0] exp_data(int i);
      logic [8:0] m = 9'(m_mul - 1);
      case (i)
         0: return 8'h80 | {2'b00, vco_rng, vco_cap, 1'b0};
         1: return {4'h0, cp_cur};
         2: return {cp_byp, lf_byp, lf_ctl};
         3: return 8'h30;
         4: return 8'(n_div - 1);
         5: return {3'b000, m[4:0]};
         default: return {4'b1000, m[8:5]};
      endcase
   endfunction

   function automatic string data_tag(int i);
      case (i)
         0: return "R2";
         1, 2: return "R4";
         3: return "R5";
         4: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic rand_cfg();
      n_div   = 8'($urandom_range(1, 255));
      m_mul   = 10'($urandom_range(1, 512));
      vco_rng = 3'($urandom);
      vco_cap = 2'($urandom_range(0, 2));
      cp_cur  = 4'($urandom);
      lf_ctl  = 6'($urandom);
      cp_byp  = 1'($urandom);
      lf_byp  = 1'($urandom);
   endtask

   // Full sequence; ack latency per write in [lo,hi]; optionally poke start while busy.
   task automatic run_cfg(input int lo, input int hi, input bit poke);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy === 1'b1 && err === 1'b0, "R9 busy/err after start", {busy, err}, 2'b10);
      for (int i = 0; i < 7; i++) begin
         int lat = $urandom_range(lo, hi);
         logic [7:0] c0 = wr_code, d0 = wr_data;
         chk(wr_req === 1'b1, "R8 request", wr_req, 1);
         chk(wr_code === exp_code(i), "R1 code order", wr_code, exp_code(i));
         chk(wr_data === exp_data(i), data_tag(i), wr_data, exp_data(i));
         for (int k = 0; k < lat; k++) begin
            if (poke && k == 0) start = 1'b1;
            @(negedge clk); start = 1'b0;
            chk(wr_req === 1'b1 && wr_code === c0 && wr_data === d0, "R8 hold", {wr_req, wr_code, wr_data}, {1'b1, c0, d0});
         end
         wr_ack = 1'b1;
         @(negedge clk); wr_ack = 1'b0;
         chk(wr_req === 1'b0, "R8 gap", wr_req, 0);
         if (i == 6) begin
            chk(done === 1'b1 && busy === 1'b0 && err === 1'b0, "R9 done", {done, busy, err}, 3'b100);
            @(negedge clk);
            chk(done === 1'b0 && wr_req === 1'b0, "R9 done pulse", {done, wr_req}, 0);
         end else begin
            chk(busy === 1'b1 && done === 1'b0, "R9 busy mid", {busy, done}, 2'b10);
            @(negedge clk);
         end
      end
   endtask

   task automatic run_tmo(input int lim);
      int cyc = 0;
      int expc = (lim == 0) ? 1 : lim;
      tmo_lim = TMO_W'(lim);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (wr_req === 1'b1 && cyc < 100) begin
         cyc++;
         @(negedge clk);
      end
      chk(cyc == expc, "R10 request length", cyc, expc);
      chk(err === 1'b1 && busy === 1'b0, "R10 abort", {err, busy}, 2'b10);
      tmo_lim = 16'd1000;
   endtask

   initial begin
      int seed;
      seed = $urandom(32'h5eed);
      repeat (3) @(negedge clk);
      chk(wr_req === 0 && busy === 0 && done === 0 && err === 0, "R11 reset", {wr_req, busy, done, err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wr_req === 0 && busy === 0, "R11 idle", {wr_req, busy}, 0);

      // Directed edges: M=512, N=1; then M=1, N=255
      n_div = 8'd1; m_mul = 10'd512; vco_rng = 3'd5; vco_cap = 2'b10;
      cp_cur = 4'h7; lf_ctl = 6'h10; cp_byp = 1; lf_byp = 0;
      run_cfg(0, 0, 0);
      n_div = 8'd255; m_mul = 10'd1; vco_cap = 2'b01; cp_byp = 0; lf_byp = 1;
      run_cfg(1, 3, 1);

      // R3: illegal capacitance refused
      vco_cap = 2'b11;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(err === 1 && busy === 0 && wr_req === 0, "R3 refuse", {err, busy, wr_req}, 3'b100);
      @(negedge clk);
      chk(wr_req === 0 && busy === 0, "R3 no write", {wr_req, busy}, 0);

      // R11: legal start clears err
      vco_cap = 2'b00;
      run_cfg(0, 2, 0);
      chk(err === 0, "R11 err cleared", err, 0);

      // R10: timeouts, then ack in exactly the last allowed cycle
      run_tmo(5);
      run_tmo(0);
      run_tmo(1);
      tmo_lim = 16'd4;
      run_cfg(3, 3, 0);
      tmo_lim = 16'd1000;

      for (int t = 0; t < 40; t++) begin
         rand_cfg();
         run_cfg(0, 6, (t % 3) == 0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule